// File: doc/BRIEF.md
# Two-Level Adaptive Branch Direction Predictor

This block guesses whether a conditional branch will be taken. The guess is made from the branch's instruction address and the outcomes of recent branches. Its core is a table of 2-bit saturating counters, and each counter is a small four-state machine. The index into the table is formed in one of three ways, chosen when the design is built:

- **Global:** one shared outcome history is placed above the low address bits.
- **Local:** a per-branch history is fetched using the address, then placed above the low address bits.
- **Hashed:** the low address bits are XORed with the shared history.

A fetch stage drives `pred_pc` and reads `pred_taken` in the same cycle; there is no register between them. When a branch resolves, the back end pulses `upd_valid` with the branch address and its real outcome. The addressed counter then moves one state toward that outcome, and the history that was used to find it shifts the outcome in. An update and a prediction may occur in the same cycle. Because all state is held in registers, the prediction in that cycle reflects the state before the update.

Each table entry is a state machine with four states:

- `CTR_SNT` (strong not-taken, 00)
- `CTR_WNT` (weak not-taken, 01)
- `CTR_WT` (weak taken, 10)
- `CTR_ST` (strong taken, 11)

Its transitions, on an update that addresses it:

- **Taken:** `CTR_SNT`→`CTR_WNT`, `CTR_WNT`→`CTR_WT`, `CTR_WT`→`CTR_ST`, and `CTR_ST`→`CTR_ST`.
- **Not-taken:** `CTR_ST`→`CTR_WT`, `CTR_WT`→`CTR_WNT`, `CTR_WNT`→`CTR_SNT`, and `CTR_SNT`→`CTR_SNT`.
- **No update:** every entry holds its state.

Top module: `tla_dir_pred`

## Requirements
- R1: After reset, every counter is in `CTR_WNT` (01) and every history register is zero, so `pred_taken` is 0 for any `pred_pc`.
- R2: `pred_taken` is 1 exactly when the addressed counter is in `CTR_WT` (10) or `CTR_ST` (11), and it follows `pred_pc` in the same cycle with no register.
- R3: An update moves the addressed counter one state toward the outcome (`upd_taken`=1 means taken). It saturates, staying in `CTR_ST` on taken and in `CTR_SNT` on not-taken.
- R4: From `CTR_ST`, one not-taken update leaves the prediction at taken (as seen again under the same history), and a second not-taken update flips it to not-taken.
- R5: Only `pc[PC_LSB +: PC_IDX_W]` (bits 5:2 by default) takes part in the address field of the index. Addresses differing only outside the bits the mode uses share one counter.
- R6: In global mode, the index is `{ghr, pc[5:2]}`, where `ghr` is a HIST_W-bit (default 2) register. On each update it shifts left and takes the outcome at bit 0.
- R7: In local mode, `pc[PC_LSB +: LHT_IDX_W]` (bits 4:2) selects one history of HIST_W bits. The index is `{that history, pc[5:2]}`. An update shifts only the selected history, with the outcome at bit 0.
- R8: In hashed mode, the index is `pc[PC_LSB +: HIST_W] ^ ghr` (bits 3:2 XOR a 2-bit `ghr`), over a table of 2^HIST_W counters. `ghr` shifts as in R6.
- R9: When an update and a prediction occur in the same cycle, `pred_taken` reflects the counter and history as they were before that update.
- R10: While `upd_valid` is 0, the values on `upd_pc` and `upd_taken` have no effect: no counter or history changes, and `pred_taken` for a fixed `pred_pc` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc | input | PC_W | Address of the branch being predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |

## Verification
The bench drives all three index modes with the same stimulus.

- **Run of taken outcomes:** drives one branch into `CTR_ST`.
- **Single not-taken, then two taken outcomes of another branch:** the other branch's outcomes restore the shared history. This separates hysteresis (R4) from a plain last-outcome bit. It also separates global from local indexing, because only the global history is moved back.
- **Addresses that differ above the index bits:** show aliasing.
- **Update and prediction on the same address in one cycle:** show that the prediction reads the pre-update state.
- **Long random mix of a few addresses and outcomes:** compared each cycle with a behavioural model of all three modes.

// File: rtl/tla_pkg.sv
package tla_pkg;

    typedef enum logic [1:0] {
        CTR_SNT = 2'b00,
        CTR_WNT = 2'b01,
        CTR_WT  = 2'b10,
        CTR_ST  = 2'b11
    } ctr_e;

    typedef enum logic [1:0] {
        IDX_GLOBAL = 2'd0,
        IDX_LOCAL  = 2'd1,
        IDX_HASHED = 2'd2
    } idx_mode_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic int tidx_width(input idx_mode_e m, input int hist_w, input int pc_w);
        return (m == IDX_HASHED) ? hist_w : hist_w + pc_w;
    endfunction

endpackage

// File: rtl/tla_hist.sv
module tla_hist
    import tla_pkg::*;
#(
    parameter idx_mode_e MODE      = IDX_GLOBAL,
    parameter int        PCF_W     = 4,
    parameter int        HIST_W    = 2,
    parameter int        LHT_IDX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PCF_W-1:0]  p_pcf,
    input  logic [PCF_W-1:0]  u_pcf,
    input  logic              upd_valid,
    input  logic              upd_taken,
    output logic [HIST_W-1:0] p_hist,
    output logic [HIST_W-1:0] u_hist
);
    localparam int LHT_D = 1 << LHT_IDX_W;

    logic unused_pcf;
    assign unused_pcf = ^{p_pcf, u_pcf};

    if (MODE == IDX_LOCAL) begin : g_local
        logic [HIST_W-1:0]    lht [LHT_D];
        logic [LHT_IDX_W-1:0] p_sel;
        logic [LHT_IDX_W-1:0] u_sel;

        assign p_sel  = p_pcf[LHT_IDX_W-1:0];
        assign u_sel  = u_pcf[LHT_IDX_W-1:0];
        assign p_hist = lht[p_sel];
        assign u_hist = lht[u_sel];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < LHT_D; i++) lht[i] <= '0;
            end else if (upd_valid) begin
                lht[u_sel] <= {u_hist[HIST_W-2:0], upd_taken};
            end
        end

        AST_LHT_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
            upd_valid |=> lht[$past(u_sel)] == {$past(u_hist[HIST_W-2:0]), $past(upd_taken)}); // R7
    end else begin : g_shared
        logic [HIST_W-1:0] ghr;

        assign p_hist = ghr;
        assign u_hist = ghr;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ghr <= '0;
            end else if (upd_valid) begin
                ghr <= {ghr[HIST_W-2:0], upd_taken};
            end
        end

        AST_GHR_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
            upd_valid |=> ghr == {$past(ghr[HIST_W-2:0]), $past(upd_taken)}); // R6
        AST_GHR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !upd_valid |=> $stable(ghr)); // R10
    end

endmodule

// File: rtl/tla_index.sv
module tla_index
    import tla_pkg::*;
#(
    parameter idx_mode_e MODE     = IDX_GLOBAL,
    parameter int        PCF_W    = 4,
    parameter int        PC_IDX_W = 4,
    parameter int        HIST_W   = 2,
    parameter int        TIDX_W   = 6
) (
    input  logic [PCF_W-1:0]  pcf,
    input  logic [HIST_W-1:0] hist,
    output logic [TIDX_W-1:0] idx
);
    logic unused_bits;
    assign unused_bits = ^pcf;

    if (MODE == IDX_HASHED) begin : g_hash
        assign idx = pcf[HIST_W-1:0] ^ hist;
    end else begin : g_concat
        assign idx = {hist, pcf[PC_IDX_W-1:0]};
    end

endmodule

// File: rtl/tla_ctr_table.sv
module tla_ctr_table
    import tla_pkg::*;
#(
    parameter int TIDX_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIDX_W-1:0] rd_idx,
    output logic              rd_taken,
    input  logic              upd_valid,
    input  logic [TIDX_W-1:0] upd_idx,
    input  logic              upd_taken
);
    localparam int DEPTH = 1 << TIDX_W;

    ctr_e tbl [DEPTH];
    ctr_e cur_state;
    ctr_e nxt_state;
    ctr_e rd_state;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) tbl[i] <= CTR_WNT;
        end else if (upd_valid) begin
            tbl[upd_idx] <= nxt_state;
        end
    end

    always_comb begin
        cur_state = tbl[upd_idx];
        nxt_state = cur_state;
        unique case (cur_state)
            CTR_SNT: nxt_state = upd_taken ? CTR_WNT : CTR_SNT;
            CTR_WNT: nxt_state = upd_taken ? CTR_WT  : CTR_SNT;
            CTR_WT:  nxt_state = upd_taken ? CTR_ST  : CTR_WNT;
            CTR_ST:  nxt_state = upd_taken ? CTR_ST  : CTR_WT;
        endcase
    end

    always_comb begin
        rd_state = tbl[rd_idx];
        rd_taken = (rd_state == CTR_WT) || (rd_state == CTR_ST);
    end

    AST_SAT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && cur_state == CTR_ST) |=> tbl[$past(upd_idx)] == CTR_ST); // R3
    AST_SAT_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && cur_state == CTR_SNT) |=> tbl[$past(upd_idx)] == CTR_SNT); // R3
    AST_STRONG_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && cur_state == CTR_ST) |=> tbl[$past(upd_idx)] == CTR_WT); // R4

endmodule

// File: rtl/tla_dir_pred.sv
module tla_dir_pred
    import tla_pkg::*;
#(
    parameter idx_mode_e MODE      = IDX_GLOBAL,
    parameter int        PC_W      = 32,
    parameter int        PC_LSB    = 2,
    parameter int        PC_IDX_W  = 4,
    parameter int        HIST_W    = 2,
    parameter int        LHT_IDX_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] pred_pc,
    output logic            pred_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);
    localparam int PCF_W  = max3(PC_IDX_W, HIST_W, LHT_IDX_W);
    localparam int TIDX_W = tidx_width(MODE, HIST_W, PC_IDX_W);

    logic [PCF_W-1:0]  p_pcf;
    logic [PCF_W-1:0]  u_pcf;
    logic [HIST_W-1:0] p_hist;
    logic [HIST_W-1:0] u_hist;
    logic [TIDX_W-1:0] p_idx;
    logic [TIDX_W-1:0] u_idx;
    logic              pc_unused;

    assign p_pcf     = pred_pc[PC_LSB +: PCF_W];
    assign u_pcf     = upd_pc[PC_LSB +: PCF_W];
    assign pc_unused = ^{pred_pc, upd_pc};

    tla_hist #(
        .MODE(MODE), .PCF_W(PCF_W), .HIST_W(HIST_W), .LHT_IDX_W(LHT_IDX_W)
    ) u_hist_unit (
        .clk(clk), .rst_n(rst_n), .p_pcf(p_pcf), .u_pcf(u_pcf),
        .upd_valid(upd_valid), .upd_taken(upd_taken),
        .p_hist(p_hist), .u_hist(u_hist)
    );

    tla_index #(
        .MODE(MODE), .PCF_W(PCF_W), .PC_IDX_W(PC_IDX_W), .HIST_W(HIST_W), .TIDX_W(TIDX_W)
    ) u_idx_pred (
        .pcf(p_pcf), .hist(p_hist), .idx(p_idx)
    );

    tla_index #(
        .MODE(MODE), .PCF_W(PCF_W), .PC_IDX_W(PC_IDX_W), .HIST_W(HIST_W), .TIDX_W(TIDX_W)
    ) u_idx_upd (
        .pcf(u_pcf), .hist(u_hist), .idx(u_idx)
    );

    tla_ctr_table #(
        .TIDX_W(TIDX_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n), .rd_idx(p_idx), .rd_taken(pred_taken),
        .upd_valid(upd_valid), .upd_idx(u_idx), .upd_taken(upd_taken)
    );

    AST_PRED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid ##1 $stable(pred_pc) |-> $stable(pred_taken)); // R10
    AST_RESET_NT: assert property (@(posedge clk)
        !rst_n |=> !pred_taken); // R1

endmodule

// File: tb/tla_dir_pred_bench.sv
module tla_dir_pred_bench;
    import tla_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pred_pc = '0;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic        pg, pl, ph;

    int checks = 0;
    int errors = 0;

    // reference state
    int cg [64];
    int cl [64];
    int chs [4];
    int ghr;
    int lht [8];

    logic got_g, got_l, got_h;

    localparam logic [31:0] PA = 32'h0000_0010;
    localparam logic [31:0] PB = 32'h0000_0024;

    always #2 clk = ~clk;

    tla_dir_pred #(.MODE(IDX_GLOBAL)) u_tla_dir_pred (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pg),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken));
    tla_dir_pred #(.MODE(IDX_LOCAL)) u_tla_dir_pred_loc (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pl),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken));
    tla_dir_pred #(.MODE(IDX_HASHED)) u_tla_dir_pred_hsh (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(ph),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken));

    function automatic int pcb(input logic [31:0] pc);
        return int'((pc >> 2) & 32'hF);
    endfunction
    function automatic int idx_g(input logic [31:0] pc);
        return ghr * 16 + pcb(pc);
    endfunction
    function automatic int idx_l(input logic [31:0] pc);
        return lht[int'((pc >> 2) & 32'h7)] * 16 + pcb(pc);
    endfunction
    function automatic int idx_h(input logic [31:0] pc);
        return int'((pc >> 2) & 32'h3) ^ ghr;
    endfunction
    function automatic int bump(input int c, input logic t);
        if (t) return (c < 3) ? c + 1 : 3;
        return (c > 0) ? c - 1 : 0;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 64; i++) begin cg[i] = 1; cl[i] = 1; end
        for (int i = 0; i < 4; i++) chs[i] = 1;
        for (int i = 0; i < 8; i++) lht[i] = 0;
        ghr = 0;
    endtask

    task automatic model_update(input logic [31:0] pc, input logic t);
        int ig, il, ih, ls;
        ig = idx_g(pc); il = idx_l(pc); ih = idx_h(pc);
        ls = int'((pc >> 2) & 32'h7);
        cg[ig] = bump(cg[ig], t);
        cl[il] = bump(cl[il], t);
        chs[ih] = bump(chs[ih], t);
        ghr = ((ghr << 1) | int'(t)) & 3;
        lht[ls] = ((lht[ls] << 1) | int'(t)) & 3;
    endtask

    task automatic check(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%0b exp=%0b", tag, got, exp);
        end
    endtask

    // one cycle: drive, compare predictions against the model (pre-update), clock, advance model
    task automatic step(input logic uv, input logic [31:0] upc, input logic ut, input logic [31:0] ppc);
        @(negedge clk);
        upd_valid = uv; upd_pc = upc; upd_taken = ut; pred_pc = ppc;
        #1;
        got_g = pg; got_l = pl; got_h = ph;
        check("R2/R6 global model", pg, cg[idx_g(ppc)] >= 2);
        check("R2/R7 local model", pl, cl[idx_l(ppc)] >= 2);
        check("R2/R8 hashed model", ph, chs[idx_h(ppc)] >= 2);
        @(posedge clk);
        if (uv) model_update(upc, ut);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog got=running exp=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [31:0] pool [5];
        pool[0] = PA; pool[1] = PB; pool[2] = 32'h0000_0038;
        pool[3] = 32'h0000_104C; pool[4] = 32'h0000_002C;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        step(1'b0, '0, 1'b0, PA);
        check("R1 global", got_g, 1'b0);
        check("R1 local", got_l, 1'b0);
        check("R1 hashed", got_h, 1'b0);
        step(1'b0, '0, 1'b0, 32'h0000_003C);
        check("R1 other pc", got_g | got_l | got_h, 1'b0);

        // five taken outcomes on PA
        for (int i = 0; i < 5; i++) step(1'b1, PA, 1'b1, 32'h0);
        step(1'b0, '0, 1'b0, PA);
        check("R3 global strong", got_g, 1'b1);
        check("R3 local strong", got_l, 1'b1);
        check("R3 hashed strong", got_h, 1'b1);
        step(1'b0, '0, 1'b0, 32'h0000_1053);
        check("R5 alias global", got_g, 1'b1);
        check("R5 alias hashed", got_h, 1'b1);

        // R9: update not-taken on PA while predicting PA
        step(1'b1, PA, 1'b0, PA);
        check("R9 global pre-update", got_g, 1'b1);
        check("R9 local pre-update", got_l, 1'b1);
        step(1'b0, '0, 1'b0, PA);
        check("R6 global history moved", got_g, 1'b0);

        // two taken on PB restore the global history
        step(1'b1, PB, 1'b1, 32'h0);
        step(1'b1, PB, 1'b1, 32'h0);
        step(1'b0, '0, 1'b0, PA);
        check("R4 global one miss keeps taken", got_g, 1'b1);
        check("R7 local history isolated", got_l, 1'b0);
        check("R8 hashed index", got_h, 1'b1);

        step(1'b1, PA, 1'b0, 32'h0);
        step(1'b1, PB, 1'b1, 32'h0);
        step(1'b1, PB, 1'b1, 32'h0);
        step(1'b0, '0, 1'b0, PA);
        check("R4 global second miss flips", got_g, 1'b0);

        // R10: update inputs move without upd_valid
        for (int i = 0; i < 6; i++) begin
            step(1'b0, PA, i[0], PA);
            check("R10 global ignores idle update", got_g, 1'b0);
        end

        // random mix
        for (int i = 0; i < 600; i++) begin
            step(($urandom % 4) != 0, pool[$urandom % 5], ($urandom % 3) != 0, pool[$urandom % 5]);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule